// File: doc/BRIEF.md
# Segmented DAC Code Path with Correction Lookup

This block sits between the second-rank data word of a self-calibrating precision DAC and its analog current sources. The four most significant bits of the word become fifteen equal-weight segment enables, ordered as a thermometer. The remaining lower bits pass unchanged to a binary-weighted ladder. A separate enable for an extra half-step current source, the extrapolation LSB, is passed through only while the calibration sequencer holds the path.

Once a valid calibration exists, the six most significant bits of the same word select one entry of a 64-entry correction memory. The stored word drives the correction DAC alongside the main code. Without a valid calibration, or while calibration is running, the correction code sits at a neutral mid value. The calibration sequencer fills the memory through a single synchronous write port. All outputs are registered together, so each analog update lands on one clock edge.

Top module: `segdac_path`

## Requirements
- R1: While rst_n is low, seg_en is all zero, ladder_code is zero, xlsb_en is 0, and corr_code is the mid code 1 << (CORR_W-1), which is 128 by default.
- R2: One edge after code_in is presented, seg_en has bit i set exactly when the value of code_in[CODE_W-1 -: 4] is greater than i, for i from 0 to 14.
- R3: One edge after code_in is presented, ladder_code equals code_in[CODE_W-5:0].
- R4: xlsb_en is 1 one edge after a cycle in which both xlsb_req and cal_busy are 1. Otherwise it is 0, so xlsb_req has no effect while cal_busy is 0.
- R5: When cal_valid is 1 and cal_busy is 0, corr_code one edge later equals the memory entry addressed by code_in[CODE_W-1 -: 6], and it changes on the same edge as seg_en and ladder_code.
- R6: When cal_valid is 0 or cal_busy is 1, corr_code one edge later is the mid code, whatever the memory holds.
- R7: When wr_en is 1, wr_data is stored at wr_addr on the clock edge. A read of that same address in the same cycle returns the old entry, and the new entry is returned from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_in | input | CODE_W | Main data word from the second-rank latch |
| cal_busy | input | 1 | Calibration sequencer owns the path |
| cal_valid | input | 1 | Correction memory holds a valid calibration |
| xlsb_req | input | 1 | Sequencer request for the extrapolation LSB |
| wr_en | input | 1 | Correction memory write strobe |
| wr_addr | input | IDX_W | Correction memory write index |
| wr_data | input | CORR_W | Correction word to store |
| seg_en | output | 15 | Thermometer enables of the equal segments |
| ladder_code | output | CODE_W-4 | Binary ladder bits |
| xlsb_en | output | 1 | Extrapolation LSB enable |
| corr_code | output | CORR_W | Correction DAC code |

## Verification
The correction lookup and a sequencer write can address the same entry in the same cycle. The bench provokes this by writing the entry that the current code_in selects while the path is calibrated, with wr_data different from the stored value. Its model then expects the old entry on corr_code at that edge and the new entry after a later edge with the same code. The bench also presents a new code_in in the same cycle as a calibration-state change, and it judges that corr_code follows the mode while seg_en and ladder_code follow the code on that same edge.

// File: rtl/segdac_path.sv
module segdac_path #(
  parameter int CODE_W = 18,
  parameter int IDX_W  = 6,
  parameter int CORR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code_in,
  input  logic              cal_busy,
  input  logic              cal_valid,
  input  logic              xlsb_req,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [CORR_W-1:0] wr_data,
  output logic [14:0]       seg_en,
  output logic [CODE_W-5:0] ladder_code,
  output logic              xlsb_en,
  output logic [CORR_W-1:0] corr_code
);
  localparam int SEG_W = 4;
  localparam int NSEG  = (1 << SEG_W) - 1;
  localparam int LAD_W = CODE_W - SEG_W;
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CORR_W-1:0] MID = CORR_W'(1) << (CORR_W - 1);

  logic [CORR_W-1:0] corr_mem [DEPTH];
  logic [SEG_W-1:0]  top;
  logic [IDX_W-1:0]  rd_idx;
  logic [NSEG-1:0]   seg_nxt;
  logic              use_corr;

  assign top      = code_in[CODE_W-1 -: SEG_W];
  assign rd_idx   = code_in[CODE_W-1 -: IDX_W];
  assign use_corr = cal_valid & ~cal_busy;

  for (genvar g = 0; g < NSEG; g++) begin : g_therm
    assign seg_nxt[g] = top > SEG_W'(g);
  end

  always_ff @(posedge clk)
    if (wr_en) corr_mem[wr_addr] <= wr_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      seg_en      <= '0;
      ladder_code <= '0;
      xlsb_en     <= 1'b0;
      corr_code   <= MID;
    end else begin
      seg_en      <= seg_nxt;
      ladder_code <= code_in[LAD_W-1:0];
      xlsb_en     <= xlsb_req & cal_busy;
      corr_code   <= use_corr ? corr_mem[rd_idx] : MID;
    end

  // R2
  seg_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((seg_en + 15'd1) & seg_en) == 15'd0);

  // R2
  seg_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $countones(seg_en) == int'($past(code_in[CODE_W-1 -: SEG_W])));

  // R3
  ladder_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ladder_code == $past(code_in[LAD_W-1:0]));

  // R4
  xlsb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_busy |=> !xlsb_en);

  // R6
  corr_neutral_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cal_valid || cal_busy) |=> corr_code == MID);
endmodule

// File: tb/segdac_path_tb.sv
module segdac_path_tb;
  localparam int CODE_W = 18;
  localparam int IDX_W  = 6;
  localparam int CORR_W = 8;
  localparam int MIDV   = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CODE_W-1:0] code_in = '0;
  logic cal_busy = 1'b0, cal_valid = 1'b0, xlsb_req = 1'b0, wr_en = 1'b0;
  logic [IDX_W-1:0]  wr_addr = '0;
  logic [CORR_W-1:0] wr_data = '0;
  logic [14:0]       seg_en;
  logic [CODE_W-5:0] ladder_code;
  logic              xlsb_en;
  logic [CORR_W-1:0] corr_code;

  always #2 clk = ~clk;

  segdac_path #(.CODE_W(CODE_W), .IDX_W(IDX_W), .CORR_W(CORR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .code_in(code_in), .cal_busy(cal_busy),
    .cal_valid(cal_valid), .xlsb_req(xlsb_req), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .seg_en(seg_en),
    .ladder_code(ladder_code), .xlsb_en(xlsb_en), .corr_code(corr_code));

  int ram_m [64];
  int exp_seg, exp_lad, exp_x, exp_corr;
  bit exp_ok = 0, in_rst = 1, corr_on = 0, collide = 0;
  int n_run = 0, n_fail = 0, cycles = 0;

  always @(posedge clk) begin
    int t, idx;
    t   = int'(code_in) >> 14;
    idx = int'(code_in) >> 12;
    if (!rst_n) begin
      exp_seg = 0; exp_lad = 0; exp_x = 0; exp_corr = MIDV; in_rst = 1;
    end else begin
      exp_seg  = (1 << t) - 1;
      exp_lad  = int'(code_in) & 16'h3FFF;
      exp_x    = (xlsb_req && cal_busy) ? 1 : 0;
      corr_on  = cal_valid && !cal_busy;
      collide  = corr_on && wr_en && (int'(wr_addr) == idx);
      exp_corr = corr_on ? ram_m[idx] : MIDV;
      in_rst   = 0;
    end
    if (wr_en) ram_m[wr_addr] = int'(wr_data);
    exp_ok = 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (exp_ok) begin
    if (in_rst) begin
      chk("R1 seg", int'(seg_en), exp_seg);
      chk("R1 ladder", int'(ladder_code), exp_lad);
      chk("R1 xlsb", int'(xlsb_en), exp_x);
      chk("R1 corr", int'(corr_code), exp_corr);
    end else begin
      chk("R2 seg", int'(seg_en), exp_seg);
      chk("R3 ladder", int'(ladder_code), exp_lad);
      chk("R4 xlsb", int'(xlsb_en), exp_x);
      if (collide)      chk("R7 corr", int'(corr_code), exp_corr);
      else if (corr_on) chk("R5 corr", int'(corr_code), exp_corr);
      else              chk("R6 corr", int'(corr_code), exp_corr);
    end
  end

  task automatic step(input logic [CODE_W-1:0] c);
    code_in = c;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2 R3 R6: uncalibrated sweep of each segment level
    for (int s = 0; s < 16; s++) step(CODE_W'((s << 14) | (s * 1021)));
    step('1);
    step('0);
    // R4: request ignored without calibration ownership
    xlsb_req = 1'b1;
    step(18'h2AAAA);
    step(18'h15555);
    // R4 R7: sequencer fills the memory while busy
    cal_busy = 1'b1;
    for (int i = 0; i < 64; i++) begin
      wr_en = 1'b1; wr_addr = IDX_W'(i); wr_data = CORR_W'(i * 37 + 5);
      xlsb_req = i[0];
      step(CODE_W'(i << 12));
    end
    wr_en = 1'b0; xlsb_req = 1'b0;
    // R6: valid but still busy stays neutral
    cal_valid = 1'b1;
    step(18'h3F000);
    // R5: calibrated lookups, mode change on the same edge as a new code
    cal_busy = 1'b0;
    step(18'h3FFFF);
    for (int i = 0; i < 60; i++) step(CODE_W'($urandom));
    // R7: write the entry being read in the same cycle
    wr_en = 1'b1; wr_addr = 6'h2B; wr_data = 8'hE1;
    step(CODE_W'(6'h2B << 12) | 18'h00123);
    wr_en = 1'b0;
    step(CODE_W'(6'h2B << 12) | 18'h00456);
    // R6: losing validity returns to mid code
    cal_valid = 1'b0;
    step(18'h2B000);
    step(18'h01234);
    // R1: reset mid-run
    rst_n = 1'b0;
    step(18'h3FFFF);
    step(18'h3FFFF);
    rst_n = 1'b1;
    step(18'h0C000);
    step(18'h0C000);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<5000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule